// File: doc/BRIEF.md
# Vector Issue Scoreboard with Deferred Arithmetic Queue

This block is the issue controller of a small vector unit that has one memory pipe (loads and stores) and one arithmetic pipe. Decoded instructions arrive in program order, at most one per cycle, over a valid/ready handshake. Each instruction carries a class, a destination register and two source register numbers. Loads and stores are dispatched straight to the memory pipe. Arithmetic instructions are written into a two-entry deferred queue and are started from its head, one at a time.

The deferred queue lets a later load start while earlier arithmetic work is still waiting. A load is held back only if its destination is an operand of a queued arithmetic instruction that has not begun. The operands of that instruction count as captured at the moment it starts. Read-after-write and write-after-write hazards are tracked per register. Both pipes are modelled as fixed-latency busy timers.

Back-pressure: an instruction is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is computed from the instruction currently presented. While it is low, the source must hold the instruction stable, and no later instruction can pass it.

Top module: `vec_issue_sb`

## Requirements
- R1: After reset `reg_busy` is all zero, `mem_go` and `alu_go` are low, and `in_ready` is high for an idle load of register 0.
- R2: An instruction is accepted only on an edge with `in_valid` and `in_ready` both high. An unblocked stream is accepted one per cycle. A stalled instruction keeps `in_ready` low and holds back every later instruction.
- R3: Class code `in_op` 00 is a load, which writes `in_dst`. Code 01 is a store, which reads `in_src_a`. A load or store pulses `mem_go` in the cycle after its acceptance. `mem_store` is 1 for a store. `mem_reg` is the load destination or the store source. The memory pipe stays busy for MEM_LAT+1 cycles, so the next memory instruction is accepted no sooner than 10 cycles later with the default parameters.
- R4: An arithmetic start pulses `alu_go` for one cycle, with `alu_dst`, `alu_src_a` and `alu_src_b` taken from the queue head. The arithmetic pipe stays busy for ALU_LAT+1 cycles (6 with the default parameters).
- R5: A load is not accepted while its destination is a source of any queued arithmetic instruction that has not yet started. The load is accepted, at the earliest, in the cycle after that instruction's start.
- R6: No instruction is accepted while its destination is the pending destination of an earlier unfinished load or arithmetic instruction.
- R7: A queued arithmetic instruction does not start while either of its sources is the destination of an unfinished load.
- R8: The deferred queue holds two arithmetic instructions. While it is full, an arithmetic instruction keeps `in_ready` low. The instruction is accepted on the edge after a head entry starts.
- R9: A store is not accepted while its source register has an unfinished load or arithmetic write.
- R10: A load whose destination no queued arithmetic instruction reads may be accepted while arithmetic work waits. Its `mem_go` may fall in the same cycle as an `alu_go`.
- R11: `reg_busy[r]` is high from the edge that accepts a writer of register r until the edge on which that write completes.
- R12: Arithmetic instructions start in program order, one at a time. An instruction starts no earlier than the cycle after its acceptance, and no earlier than the cycle after the previous arithmetic instruction completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction presented |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| in_op | input | 2 | Class: 00 load, 01 store, 1x arithmetic |
| in_dst | input | RW | Destination register (load, arithmetic) |
| in_src_a | input | RW | First source (store data register, arithmetic operand) |
| in_src_b | input | RW | Second arithmetic operand |
| mem_go | output | 1 | One-cycle memory dispatch pulse |
| mem_store | output | 1 | Dispatched memory instruction is a store |
| mem_reg | output | RW | Load destination or store source of the last memory dispatch |
| alu_go | output | 1 | One-cycle arithmetic start pulse |
| alu_dst | output | RW | Destination of the last started arithmetic instruction |
| alu_src_a | output | RW | First source of the last started arithmetic instruction |
| alu_src_b | output | RW | Second source of the last started arithmetic instruction |
| reg_busy | output | NREG | Per-register pending-write flags |

## Verification
A load dispatch and the start of a deferred arithmetic instruction can fall in the same cycle. The bench provokes this with a load, then an arithmetic instruction that reads that load's result, then a load to an unrelated register. It expects `mem_go` and `alu_go` both on offset 11. The same sequence is repeated with the second load aimed at the queued instruction's operand. There the load must land exactly one cycle after the start, which tells the overlap case apart from the conflict case. Every pulse is compared against a hand-computed cycle offset and register.

// File: rtl/vis_pkg.sv
package vis_pkg;
  // Instruction class carried on in_op
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_ARI0  = 2'b10,
    OP_ARI1  = 2'b11
  } op_e;

  function automatic logic op_is_arith(input op_e op);
    return op[1];
  endfunction
endpackage

// File: rtl/vis_busy_timer.sv
module vis_busy_timer #(
  parameter int LAT = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic done
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] LOAD = CW'(LAT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (start)   cnt <= LOAD;
    else if (!idle)   cnt <= cnt - CW'(1);
  end

  assign idle = (cnt == '0);
  assign done = (cnt == CW'(1));

  // R3 / R4: a pipe is never restarted while it is still occupied
  a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> idle);
endmodule

// File: rtl/vis_defer_q.sv
module vis_defer_q #(
  parameter int DEPTH = 2,
  parameter int NREG  = 8,
  parameter int RW    = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [RW-1:0]   push_dst,
  input  logic [RW-1:0]   push_sa,
  input  logic [RW-1:0]   push_sb,
  input  logic            pop,
  output logic [RW-1:0]   head_dst,
  output logic [RW-1:0]   head_sa,
  output logic [RW-1:0]   head_sb,
  output logic            empty,
  output logic            full,
  output logic [NREG-1:0] rd_mask
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [RW-1:0]    dst_m [DEPTH];
  logic [RW-1:0]    sa_m  [DEPTH];
  logic [RW-1:0]    sb_m  [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [PW-1:0]    wp, rp;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      vld <= '0;
    end else begin
      if (push) begin
        vld[wp] <= 1'b1;
        wp      <= nxt(wp);
      end
      if (pop) begin
        vld[rp] <= 1'b0;
        rp      <= nxt(rp);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      dst_m[wp] <= push_dst;
      sa_m[wp]  <= push_sa;
      sb_m[wp]  <= push_sb;
    end
  end

  assign head_dst = dst_m[rp];
  assign head_sa  = sa_m[rp];
  assign head_sb  = sb_m[rp];
  assign empty    = (vld == '0);
  assign full     = &vld;

  // Registers read by any entry that has not yet started
  always_comb begin
    rd_mask = '0;
    for (int i = 0; i < DEPTH; i++) begin
      for (int r = 0; r < NREG; r++) begin
        if (vld[i] && (sa_m[i] == RW'(r) || sb_m[i] == RW'(r)))
          rd_mask[r] = 1'b1;
      end
    end
  end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/vis_reg_track.sv
module vis_reg_track #(
  parameter int NREG = 8,
  parameter int RW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_set,
  input  logic [RW-1:0]   ld_set_idx,
  input  logic            ld_clr,
  input  logic [RW-1:0]   ld_clr_idx,
  input  logic            ar_set,
  input  logic [RW-1:0]   ar_set_idx,
  input  logic            ar_clr,
  input  logic [RW-1:0]   ar_clr_idx,
  output logic [NREG-1:0] lpend,
  output logic [NREG-1:0] apend
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic lp_q, ap_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 lp_q <= 1'b0;
      else if (ld_set && ld_set_idx == RW'(r))    lp_q <= 1'b1;
      else if (ld_clr && ld_clr_idx == RW'(r))    lp_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 ap_q <= 1'b0;
      else if (ar_set && ar_set_idx == RW'(r))    ap_q <= 1'b1;
      else if (ar_clr && ar_clr_idx == RW'(r))    ap_q <= 1'b0;
    end

    assign lpend[r] = lp_q;
    assign apend[r] = ap_q;
  end

  // R6: a register never has two outstanding writers
  a_r6_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    (lpend & apend) == '0);
  a_r6_load_set_free: assert property (@(posedge clk) disable iff (!rst_n)
    ld_set |-> !(lpend[ld_set_idx] || apend[ld_set_idx]));
  a_r6_arith_set_free: assert property (@(posedge clk) disable iff (!rst_n)
    ar_set |-> !(lpend[ar_set_idx] || apend[ar_set_idx]));
endmodule

// File: rtl/vec_issue_sb.sv
module vec_issue_sb #(
  parameter int NREG    = 8,
  parameter int QDEPTH  = 2,
  parameter int MEM_LAT = 9,
  parameter int ALU_LAT = 5,
  localparam int RW     = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      in_op,
  input  logic [RW-1:0]   in_dst,
  input  logic [RW-1:0]   in_src_a,
  input  logic [RW-1:0]   in_src_b,
  output logic            mem_go,
  output logic            mem_store,
  output logic [RW-1:0]   mem_reg,
  output logic            alu_go,
  output logic [RW-1:0]   alu_dst,
  output logic [RW-1:0]   alu_src_a,
  output logic [RW-1:0]   alu_src_b,
  output logic [NREG-1:0] reg_busy
);
  import vis_pkg::*;

  op_e  op;
  logic is_load, is_store, is_arith;
  logic [NREG-1:0] lpend, apend, busy, q_rd;
  logic mem_idle, mem_done, alu_idle, alu_done;
  logic q_empty, q_full;
  logic [RW-1:0] hd_dst, hd_sa, hd_sb;
  logic rdy, acc, mem_start, q_push, alu_start;

  assign op       = op_e'(in_op);
  assign is_arith = op_is_arith(op);
  assign is_load  = (op == OP_LOAD);
  assign is_store = (op == OP_STORE);
  assign busy     = lpend | apend;

  // Hazard checks on the presented instruction
  always_comb begin
    case (op)
      OP_LOAD:  rdy = mem_idle && !busy[in_dst] && !q_rd[in_dst];
      OP_STORE: rdy = mem_idle && !busy[in_src_a];
      default:  rdy = !q_full && !busy[in_dst];
    endcase
  end

  assign in_ready  = rdy;
  assign acc       = in_valid && rdy;
  assign mem_start = acc && !is_arith;
  assign q_push    = acc && is_arith;
  assign alu_start = !q_empty && alu_idle && !lpend[hd_sa] && !lpend[hd_sb];

  vis_busy_timer #(.LAT(MEM_LAT)) u_mem_tmr (
    .clk(clk), .rst_n(rst_n), .start(mem_start), .idle(mem_idle), .done(mem_done)
  );

  vis_busy_timer #(.LAT(ALU_LAT)) u_alu_tmr (
    .clk(clk), .rst_n(rst_n), .start(alu_start), .idle(alu_idle), .done(alu_done)
  );

  vis_defer_q #(.DEPTH(QDEPTH), .NREG(NREG), .RW(RW)) u_q (
    .clk(clk), .rst_n(rst_n),
    .push(q_push), .push_dst(in_dst), .push_sa(in_src_a), .push_sb(in_src_b),
    .pop(alu_start),
    .head_dst(hd_dst), .head_sa(hd_sa), .head_sb(hd_sb),
    .empty(q_empty), .full(q_full), .rd_mask(q_rd)
  );

  vis_reg_track #(.NREG(NREG), .RW(RW)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .ld_set(mem_start && is_load), .ld_set_idx(in_dst),
    .ld_clr(mem_done && !mem_store), .ld_clr_idx(mem_reg),
    .ar_set(q_push), .ar_set_idx(in_dst),
    .ar_clr(alu_done), .ar_clr_idx(alu_dst),
    .lpend(lpend), .apend(apend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_go    <= 1'b0;
      mem_store <= 1'b0;
      mem_reg   <= '0;
      alu_go    <= 1'b0;
      alu_dst   <= '0;
      alu_src_a <= '0;
      alu_src_b <= '0;
    end else begin
      mem_go <= mem_start;
      alu_go <= alu_start;
      if (mem_start) begin
        mem_store <= is_store;
        mem_reg   <= is_store ? in_src_a : in_dst;
      end
      if (alu_start) begin
        alu_dst   <= hd_dst;
        alu_src_a <= hd_sa;
        alu_src_b <= hd_sb;
      end
    end
  end

  assign reg_busy = busy;

  // R5: a dispatched load never targets an operand of a waiting arithmetic entry
  a_r5_load_war: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_go && !mem_store) |-> !q_rd[mem_reg]);
  // R7: arithmetic starts only after loads feeding it have finished
  a_r7_raw_load: assert property (@(posedge clk) disable iff (!rst_n)
    alu_go |-> (!lpend[alu_src_a] && !lpend[alu_src_b]));
  // R9: a store reads only completed registers
  a_r9_store_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_go && mem_store) |-> !busy[mem_reg]);
  // R12: one arithmetic start at a time
  a_r12_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    alu_go |=> !alu_go);
endmodule

// File: tb/tb_vec_issue_sb.sv
module tb_vec_issue_sb;
  localparam int NREG = 8;
  localparam int RW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_op = 2'b00;
  logic [RW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic mem_go, mem_store, alu_go;
  logic [RW-1:0] mem_reg, alu_dst, alu_src_a, alu_src_b;
  logic [NREG-1:0] reg_busy;

  always #5 clk = ~clk;

  vec_issue_sb dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .mem_go(mem_go), .mem_store(mem_store), .mem_reg(mem_reg),
    .alu_go(alu_go), .alu_dst(alu_dst), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b),
    .reg_busy(reg_busy)
  );

  int cyc = 0;
  int base = 0;
  int checks = 0;
  int fails = 0;
  int mq_off[$], mq_key[$], mq_rq[$];
  int aq_off[$], aq_reg[$], aq_rq[$];

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Expected memory dispatch: key = store*16 + register
  task automatic exp_mem(input int off, input int rg, input int st, input int rq);
    mq_off.push_back(off);
    mq_key.push_back(st * 16 + rg);
    mq_rq.push_back(rq);
  endtask

  task automatic exp_alu(input int off, input int rg, input int rq);
    aq_off.push_back(off);
    aq_reg.push_back(rg);
    aq_rq.push_back(rq);
  endtask

  // Monitor: pops expectations as pulses appear
  always @(negedge clk) begin
    int eo, ek, er;
    if (rst_n) begin
      if (mem_go) begin
        if (mq_off.size() == 0) check(1'b0, "R3 unexpected memory dispatch", cyc - base, -1);
        else begin
          eo = mq_off.pop_front();
          ek = mq_key.pop_front();
          er = mq_rq.pop_front();
          check(cyc - base == eo, $sformatf("R%0d memory dispatch cycle", er), cyc - base, eo);
          check(int'(mem_store) * 16 + int'(mem_reg) == ek,
                $sformatf("R%0d memory dispatch store*16+reg", er),
                int'(mem_store) * 16 + int'(mem_reg), ek);
        end
      end
      if (alu_go) begin
        if (aq_off.size() == 0) check(1'b0, "R4 unexpected arithmetic start", cyc - base, -1);
        else begin
          eo = aq_off.pop_front();
          ek = aq_reg.pop_front();
          er = aq_rq.pop_front();
          check(cyc - base == eo, $sformatf("R%0d arithmetic start cycle", er), cyc - base, eo);
          check(int'(alu_dst) == ek, $sformatf("R%0d arithmetic start dst", er), int'(alu_dst), ek);
        end
      end
    end
  end

  task automatic begin_sc();
    @(negedge clk);
    base = cyc;
  endtask

  task automatic send(input logic [1:0] op, input int d, input int a, input int b, output int acc);
    in_valid = 1'b1;
    in_op    = op;
    in_dst   = 3'(d);
    in_src_a = 3'(a);
    in_src_b = 3'(b);
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    acc = cyc - base;
  endtask

  task automatic quiesce();
    in_valid = 1'b0;
    repeat (45) @(negedge clk);
    check(mq_off.size() == 0 && aq_off.size() == 0, "R2 all expected dispatches seen",
          mq_off.size() + aq_off.size(), 0);
    check(reg_busy == '0, "R11 busy flags clear when idle", int'(reg_busy), 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int a;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
    check(reg_busy == '0, "R1 busy clear after reset", int'(reg_busy), 0);
    check(!mem_go && !alu_go, "R1 no dispatch after reset", int'(mem_go) + int'(alu_go), 0);

    // Sequence: two loads, two arithmetic ops, a store
    begin_sc();
    exp_mem(1, 1, 0, 3);   // R3
    exp_mem(11, 2, 0, 3);  // R3 pipe occupancy
    exp_alu(13, 3, 12);    // R12
    exp_alu(22, 2, 6);     // R6 waits for load r2
    exp_mem(28, 2, 1, 9);  // R9 waits for arithmetic r2
    send(2'b00, 1, 0, 0, a);
    send(2'b00, 2, 0, 0, a);
    check(a == 11, "R3 second load acceptance", a, 11);
    send(2'b10, 3, 1, 1, a);
    check(a == 12, "R2 arithmetic accepted next cycle", a, 12);
    send(2'b10, 2, 1, 2, a);
    check(a == 21, "R6 write-after-write stall", a, 21);
    send(2'b01, 0, 2, 0, a);
    check(a == 28, "R9 store waits for producer", a, 28);
    quiesce();

    // Overlap: independent load next to a deferred arithmetic op
    begin_sc();
    exp_mem(1, 1, 0, 3);
    exp_alu(11, 3, 7);     // R7 waits for load r1
    exp_mem(11, 4, 0, 10); // R10 same cycle as arithmetic start
    send(2'b00, 1, 0, 0, a);
    check(reg_busy == 8'h02, "R11 busy set by load", int'(reg_busy), 2);
    send(2'b10, 3, 1, 1, a);
    send(2'b00, 4, 0, 0, a);
    check(a == 11, "R10 independent load overlaps", a, 11);
    quiesce();

    // Conflict: load onto an operand of the deferred arithmetic op
    begin_sc();
    exp_mem(1, 1, 0, 3);
    exp_alu(11, 3, 7);
    exp_mem(12, 1, 0, 5);  // R5 one cycle after the start
    send(2'b00, 1, 0, 0, a);
    send(2'b10, 3, 1, 1, a);
    send(2'b00, 1, 0, 0, a);
    check(a == 12, "R5 load waits for arithmetic start", a, 12);
    quiesce();

    // Queue full
    begin_sc();
    exp_alu(2, 1, 12);
    exp_alu(8, 4, 12);
    exp_alu(14, 5, 8);
    exp_alu(20, 6, 8);     // R8
    send(2'b10, 1, 2, 3, a);
    send(2'b11, 4, 2, 3, a);
    check(a == 2, "R2 back-to-back acceptance", a, 2);
    send(2'b10, 5, 2, 3, a);
    check(a == 3, "R8 second queue entry", a, 3);
    send(2'b10, 6, 2, 3, a);
    check(a == 9, "R8 full queue stalls", a, 9);
    quiesce();

    // Store after arithmetic producer
    begin_sc();
    exp_alu(2, 3, 4);      // R4
    exp_mem(8, 3, 1, 9);   // R9
    send(2'b10, 3, 2, 2, a);
    send(2'b01, 0, 3, 0, a);
    check(a == 8, "R9 store after arithmetic completes", a, 8);
    quiesce();

    // Arithmetic write-after-write on a load destination
    begin_sc();
    exp_mem(1, 5, 0, 3);
    exp_alu(12, 5, 6);
    send(2'b00, 5, 0, 0, a);
    send(2'b10, 5, 6, 6, a);
    check(a == 11, "R6 arithmetic waits for load write", a, 11);
    quiesce();

    // Arithmetic read-after-write on a load
    begin_sc();
    exp_mem(1, 6, 0, 3);
    exp_alu(11, 7, 7);
    send(2'b00, 6, 0, 0, a);
    send(2'b10, 7, 6, 0, a);
    check(a == 2, "R7 arithmetic queued immediately", a, 2);
    quiesce();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule